// File: doc/BRIEF.md
# Sixteen-Source Vectored Priority Interrupt Controller

This block arbitrates between sixteen interrupt sources by fixed priority, source 15 being the most urgent. Each source has four bits of state: an enable bit, a pending bit, a mask bit and an in-service bit. The state is grouped into a low register of eight bits and a high register of eight bits for each kind. A one-cycle event pulse on a source's input marks it pending if its enable bit is set. When an unmasked pending source outranks everything currently in service, the block raises a single request line.

The processor answers the request with a one-cycle acknowledge strobe. The controller then returns an 8-bit vector. The vector carries a 3-bit programmable base, the 4-bit number of the winning source, and a zero in bit 0. The acknowledge also clears the winner's pending bit.

An optional nesting mode records acknowledged sources in the in-service registers. While a source is in service, sources of equal and lower priority are held off until software clears its in-service bit. Software reaches all state through a simple write port and a registered read port.

Top module: `vec_intc_top`

## Requirements
- R1: After reset, every enable, pending, mask, in-service and control bit is 0, `irq` is 0 and `vec_valid` is 0.
- R2: The register addresses are as follows: 0/1 enable low/high, 2/3 pending low/high, 4/5 mask low/high, 6/7 in-service low/high, and 8 control. In each low register, bit i belongs to source i. In each high register, bit i belongs to source 8+i. The control register has bit 0 as the nesting enable and bits 3:1 as the vector base. `rd_data` shows the register selected by `rd_addr` one cycle later.
- R3: A pulse on `src_evt[i]` sets pending bit i only when enable bit i is 1. Writing 0 to an enable bit also clears that source's pending bit.
- R4: Writing a pending register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R5: A mask bit of 0 keeps its source from requesting. A mask bit of 1 lets the source request.
- R6: `irq` is registered. It is 1 one cycle after the state shows some pending, unmasked source whose number is greater than that of every in-service source.
- R7: Among eligible sources, the one with the highest number wins.
- R8: One cycle after `ack`, `vec_valid` pulses. `vec` then holds the base in bits 7:5, the winning source number in bits 4:1, and 0 in bit 0.
- R9: An acknowledge clears the winner's pending bit. An acknowledge with no eligible source leaves `vec_valid` at 0.
- R10: With nesting enabled, an acknowledge sets the winner's in-service bit. The set bit blocks requests from sources of equal and lower number.
- R11: Writing an in-service register clears each bit written as 0 and leaves each bit written as 1 unchanged. While nesting is disabled, all in-service bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 16 | One-cycle event pulse per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Registered read data |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq | output | 1 | Interrupt request |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec | output | 8 | Interrupt vector |

## Verification
The bench builds the block with its default parameters: two banks of eight sources and a 3-bit base. These defaults put both bank boundaries within reach, namely source 7 against source 8 and source 15 as the top priority. They also allow a non-zero base to be checked bit by bit in every vector.

The directed scenarios cover the following cases:
- three sources pending at once, split across both banks, drained by acknowledge in priority order;
- a masked source that later becomes unmasked;
- events that arrive while the source's enable bit is 0;
- nesting where a lower source and an equal source are both held off;
- nesting switched off while a source is still in service.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Register kinds; address = kind * NBANK + bank
  typedef enum logic [1:0] {
    KIND_EN   = 2'd0,
    KIND_PEND = 2'd1,
    KIND_MASK = 2'd2,
    KIND_ISR  = 2'd3
  } reg_kind_e;

  localparam int NUM_KINDS = 4;
endpackage

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Highest set bit wins: later iterations override earlier ones
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  always_comb begin
    if (found) begin
      // R7
      prio_hit_chk: assert (req[idx]);
      // R7
      prio_top_chk: assert (((req >> idx) >> 1) == '0);
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_en,
  input  logic          we_pend,
  input  logic          we_mask,
  input  logic          we_isr,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] evt,
  input  logic [BW-1:0] ack_clr,
  input  logic [BW-1:0] isr_set,
  input  logic          nest_en,
  output logic [BW-1:0] en_o,
  output logic [BW-1:0] pend_o,
  output logic [BW-1:0] mask_o,
  output logic [BW-1:0] isr_o
);
  logic [BW-1:0] en_q, pend_q, mask_q, isr_q;
  logic [BW-1:0] en_n, pend_n, mask_n, isr_n;

  always_comb begin
    en_n   = we_en ? wdata : en_q;
    // write-0 clear, acknowledge clear, then new events; all gated by enable
    pend_n = (((we_pend ? (pend_q & wdata) : pend_q) & ~ack_clr) | evt) & en_n;
    mask_n = we_mask ? wdata : mask_q;
    isr_n  = nest_en ? ((we_isr ? (isr_q & wdata) : isr_q) | isr_set) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      mask_q <= '0;
      isr_q  <= '0;
    end else begin
      en_q   <= en_n;
      pend_q <= pend_n;
      mask_q <= mask_n;
      isr_q  <= isr_n;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign isr_o  = isr_q;

  // R3
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0 && !we_en) |=> (pend_q == '0));

  // R11
  isr_off_chk: assert property (@(posedge clk) disable iff (rst)
    !nest_en |=> (isr_q == '0));
endmodule

// File: rtl/vec_intc_top.sv
module vec_intc_top #(
  parameter  int NBANK  = 2,
  parameter  int BW     = 8,
  parameter  int BASE_W = 3,
  localparam int NSRC   = NBANK * BW,
  localparam int IDX_W  = $clog2(NSRC),
  localparam int VEC_W  = BASE_W + IDX_W + 1,
  localparam int CTRL_W = BASE_W + 1,
  localparam int CTRL_ADDR = intc_pkg::NUM_KINDS * NBANK,
  localparam int ADDR_W = $clog2(CTRL_ADDR + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BW-1:0]     rd_data,
  input  logic              ack,
  output logic              irq,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec
);
  import intc_pkg::*;

  logic [NSRC-1:0]   en_all, pend_all, mask_all, isr_all;
  logic [NSRC-1:0]   ack_clr_all, isr_set_all;
  logic [CTRL_W-1:0] ctrl_q;
  logic              nest_en;
  logic [BASE_W-1:0] vec_base;

  assign nest_en  = ctrl_q[0];
  assign vec_base = ctrl_q[CTRL_W-1:1];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic we_en_b, we_pend_b, we_mask_b, we_isr_b;
    assign we_en_b   = wr_en && (wr_addr == ADDR_W'(int'(KIND_EN)   * NBANK + b));
    assign we_pend_b = wr_en && (wr_addr == ADDR_W'(int'(KIND_PEND) * NBANK + b));
    assign we_mask_b = wr_en && (wr_addr == ADDR_W'(int'(KIND_MASK) * NBANK + b));
    assign we_isr_b  = wr_en && (wr_addr == ADDR_W'(int'(KIND_ISR)  * NBANK + b));

    intc_bank #(.BW(BW)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .we_en   (we_en_b),
      .we_pend (we_pend_b),
      .we_mask (we_mask_b),
      .we_isr  (we_isr_b),
      .wdata   (wr_data),
      .evt     (src_evt[b*BW +: BW]),
      .ack_clr (ack_clr_all[b*BW +: BW]),
      .isr_set (isr_set_all[b*BW +: BW]),
      .nest_en (nest_en),
      .en_o    (en_all[b*BW +: BW]),
      .pend_o  (pend_all[b*BW +: BW]),
      .mask_o  (mask_all[b*BW +: BW]),
      .isr_o   (isr_all[b*BW +: BW])
    );
  end

  // Arbitration: best eligible source against best in-service source
  logic             win_found, isr_found, win_ok;
  logic [IDX_W-1:0] win_idx, isr_idx;

  intc_prio #(.N(NSRC), .IW(IDX_W)) u_win_prio (
    .req   (pend_all & mask_all),
    .found (win_found),
    .idx   (win_idx)
  );

  intc_prio #(.N(NSRC), .IW(IDX_W)) u_isr_prio (
    .req   (isr_all),
    .found (isr_found),
    .idx   (isr_idx)
  );

  assign win_ok      = win_found && (!isr_found || (win_idx > isr_idx));
  assign ack_clr_all = (ack && win_ok) ? (NSRC'(1) << win_idx) : '0;
  assign isr_set_all = nest_en ? ack_clr_all : '0;

  logic [BW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (rd_addr == ADDR_W'(int'(KIND_EN)   * NBANK + b)) rd_mux = en_all[b*BW +: BW];
      if (rd_addr == ADDR_W'(int'(KIND_PEND) * NBANK + b)) rd_mux = pend_all[b*BW +: BW];
      if (rd_addr == ADDR_W'(int'(KIND_MASK) * NBANK + b)) rd_mux = mask_all[b*BW +: BW];
      if (rd_addr == ADDR_W'(int'(KIND_ISR)  * NBANK + b)) rd_mux = isr_all[b*BW +: BW];
    end
    if (rd_addr == ADDR_W'(CTRL_ADDR)) rd_mux = BW'(ctrl_q);
  end

  logic             irq_q, vld_q;
  logic [VEC_W-1:0] vec_q;
  logic [BW-1:0]    rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
      vld_q  <= 1'b0;
      vec_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= wr_data[CTRL_W-1:0];
      irq_q <= win_ok;
      vld_q <= ack && win_ok;
      if (ack && win_ok) vec_q <= {vec_base, win_idx, 1'b0};
      rd_q  <= rd_mux;
    end
  end

  assign irq       = irq_q;
  assign vec_valid = vld_q;
  assign vec       = vec_q;
  assign rd_data   = rd_q;

  // R8
  vld_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> $past(ack));

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && win_ok && !src_evt[win_idx]) |=> !pend_all[$past(win_idx)]);

  // R10
  isr_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && win_ok && nest_en) |=> isr_all[$past(win_idx)]);

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(pend_all & mask_all) != '0);
endmodule

// File: tb/vec_intc_top_tb.sv
`timescale 1ns/1ps
module vec_intc_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_evt = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        ack = 1'b0;
  logic        irq, vec_valid;
  logic [7:0]  vec;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vec_intc_top u_dut (
    .clk(clk), .rst(rst), .src_evt(src_evt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ack(ack),
    .irq(irq), .vec_valid(vec_valid), .vec(vec)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_evt = '0; wr_en = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic pulse(input logic [15:0] m);
    @(negedge clk);
    src_evt = m;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic open_all(input logic [7:0] ctrl);
    wr(4'd0, 8'hFF); wr(4'd1, 8'hFF);
    wr(4'd4, 8'hFF); wr(4'd5, 8'hFF);
    wr(4'd8, ctrl);
  endtask

  task automatic t_reset();
    int d;
    do_reset();
    check("R1 irq", int'(irq), 0);
    check("R1 vec_valid", int'(vec_valid), 0);
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), d);
      check($sformatf("R1 R2 reg%0d", a), d, 0);
    end
    // empty acknowledge
    do_ack();
    check("R9 empty ack vec_valid", int'(vec_valid), 0);
  endtask

  task automatic t_enable();
    int d;
    do_reset();
    pulse(16'h0008);
    rd(4'd2, d);
    check("R3 disabled event ignored", d, 0);
    wr(4'd0, 8'h08);
    pulse(16'h0008);
    rd(4'd2, d);
    check("R3 enabled event pends", d, 8'h08);
    wr(4'd1, 8'h01);
    pulse(16'h0100);
    rd(4'd3, d);
    check("R2 high bank bit0 is source 8", d, 8'h01);
    wr(4'd0, 8'h00);
    rd(4'd2, d);
    check("R3 enable clear drops pending", d, 0);
  endtask

  task automatic t_pend_write();
    int d;
    do_reset();
    wr(4'd0, 8'hFF);
    pulse(16'h0050);
    wr(4'd2, 8'hEF);
    rd(4'd2, d);
    check("R4 write 0 clears", d, 8'h40);
    wr(4'd2, 8'hFF);
    rd(4'd2, d);
    check("R4 write 1 keeps", d, 8'h40);
  endtask

  task automatic t_mask();
    wr(4'd4, 8'h00);
    settle();
    check("R5 masked no irq", int'(irq), 0);
    wr(4'd4, 8'h40);
    settle();
    check("R5 R6 unmasked irq", int'(irq), 1);
  endtask

  task automatic t_priority();
    int d;
    do_reset();
    open_all(8'h0A);
    pulse(16'h2204);
    settle();
    check("R6 irq raised", int'(irq), 1);
    do_ack();
    check("R8 vec_valid", int'(vec_valid), 1);
    check("R7 R8 vector src13", int'(vec), 8'hBA);
    @(negedge clk);
    check("R8 vec_valid one cycle", int'(vec_valid), 0);
    rd(4'd3, d);
    check("R9 winner pending cleared", d, 8'h02);
    do_ack();
    check("R7 vector src9", int'(vec), 8'hB2);
    do_ack();
    check("R7 vector src2 bank boundary", int'(vec), 8'hA4);
    settle();
    check("R6 irq drops when empty", int'(irq), 0);
    do_ack();
    check("R9 ack with none", int'(vec_valid), 0);
  endtask

  task automatic t_nest();
    int d;
    do_reset();
    open_all(8'h0B);
    pulse(16'h0400);
    settle();
    do_ack();
    check("R10 vector src10", int'(vec), 8'hB4);
    rd(4'd7, d);
    check("R10 in-service set", d, 8'h04);
    pulse(16'h0080);
    settle();
    check("R10 lower blocked", int'(irq), 0);
    pulse(16'h1000);
    settle();
    check("R10 higher requests", int'(irq), 1);
    do_ack();
    check("R10 vector src12", int'(vec), 8'hB8);
    rd(4'd7, d);
    check("R10 nested in-service", d, 8'h14);
    wr(4'd7, 8'hEF);
    rd(4'd7, d);
    check("R11 write 0 clears in-service", d, 8'h04);
    pulse(16'h0400);
    settle();
    check("R10 equal blocked", int'(irq), 0);
    wr(4'd8, 8'h0A);
    settle();
    rd(4'd7, d);
    check("R11 in-service zero when off", d, 0);
    check("R11 irq after nesting off", int'(irq), 1);
    do_ack();
    check("R11 vector src10 again", int'(vec), 8'hB4);
    rd(4'd8, d);
    check("R2 control readback", d, 8'h0A);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_pend_write();
    t_mask();
    t_priority();
    t_nest();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule